// File: doc/BRIEF.md
# Sliding-Window Activate Rate Limiter

This block guards a DRAM controller against bursts of row activates to a single rank. Each rank has a fixed-length history register. On every core clock the register shifts by one place and takes in a 1 when an activate went to that rank in that clock, or a 0 when none did. A selectable window keeps only the newest part of that history; bits older than the window are masked to zero. The block counts the ones left inside the window and compares that count with a programmable limit. When the count has reached the limit, the rank's permit output goes low and stays low until enough old activates leave the window.

The scheduler drives a request line per rank and reads back a permit line for each rank. It reports every activate it actually issues on the per-rank issued strobe. Ranks are grouped in pairs that sit on one module, and each pair has a single throttle enable. The window length and the limit are shared by all ranks.

Top module: `act_rate_limiter`

## Requirements
- R1: An activate reported on `act_issued[r]` in one clock is part of rank r's count from the next clock onward, and never in the clock it was issued.
- R2: A rank's count is the number of clocks, among the most recent W clocks, that carried an activate to that rank, where W is the selected window length.
- R3: With throttling enabled for the rank and its count greater than or equal to `act_limit`, `act_permit[r]` is 0.
- R4: With throttling enabled, `act_req[r]` high and the count below `act_limit`, `act_permit[r]` is 1.
- R5: `win_sel` picks the window length: 0 gives 10 clocks, 1 gives 13, 2 gives 15 and 3 gives 20.
- R6: An activate older than the selected window has no effect on the permit, even though the history register still holds it.
- R7: Enable bit `thr_en[m]` controls ranks 2m and 2m+1 together, and has no effect on any other rank.
- R8: With throttling disabled for a rank, `act_permit[r]` equals `act_req[r]`.
- R9: History is recorded while throttling is disabled, so turning the enable on blocks a rank at once if its count is already at the limit.
- R10: `act_permit[r]` is 0 whenever `act_req[r]` is 0.
- R11: Reset clears every history register, so every requesting rank is permitted in the first clock after reset.
- R12: An `act_limit` of 0 blocks every rank whose throttle is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_issued | input | NUM_RANKS | Activate sent to the rank in this clock |
| act_req | input | NUM_RANKS | Scheduler would like to send an activate to the rank |
| thr_en | input | NUM_RANKS/2 | Throttle enable, one bit for each pair of ranks |
| win_sel | input | 2 | Window length select (R5 encoding) |
| act_limit | input | 3 | Maximum number of activates allowed in the window |
| act_permit | output | NUM_RANKS | Activate allowed to the rank in this clock |

## Verification
The assertions assume that `win_sel` does not change during a burst whose count they follow. They also assume that `act_issued` may assert for any rank in any clock, including a rank whose permit is low, because the history must record whatever was actually sent. The stimulus changes `win_sel` only after idle stretches longer than the longest window. It drives issued strobes that mostly follow the expected permit, and it injects a few that ignore the permit so that counts go above the limit. The reference model keeps a list of issue times for each rank and works out the expected permit from the age of each entry.

// File: rtl/arl_pkg.sv
package arl_pkg;

   // Window length codes; the value order is part of the interface.
   typedef enum logic [1:0] {
      WIN_SHORT = 2'd0,
      WIN_MID   = 2'd1,
      WIN_LONG  = 2'd2,
      WIN_SAFE  = 2'd3
   } win_code_t;

   localparam int WIN_SHORT_LEN = 10;
   localparam int WIN_MID_LEN   = 13;
   localparam int WIN_LONG_LEN  = 15;
   localparam int WIN_SAFE_LEN  = 20;

   localparam int LIMIT_W = 3;

   function automatic int win_len_of(input win_code_t code);
      case (code)
         WIN_SHORT: return WIN_SHORT_LEN;
         WIN_MID:   return WIN_MID_LEN;
         WIN_LONG:  return WIN_LONG_LEN;
         default:   return WIN_SAFE_LEN;
      endcase
   endfunction

endpackage

// File: rtl/arl_window_mask.sv
module arl_window_mask
   import arl_pkg::*;
#(
   parameter int HIST_LEN = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          win_sel,
   output logic [HIST_LEN-1:0] win_mask
);

   localparam int LEN_W = $clog2(HIST_LEN + 1);

   logic [LEN_W-1:0] len_q;

   always_comb begin
      len_q = LEN_W'(win_len_of(win_code_t'(win_sel)));
   end

   // Bit 0 is the newest history entry; keep bits younger than the window.
   for (genvar b = 0; b < HIST_LEN; b++) begin : g_bit
      assign win_mask[b] = (LEN_W'(b) < len_q);
   end

   if (WIN_SAFE_LEN > HIST_LEN) begin : g_len_chk
      $error("arl_window_mask: longest window exceeds HIST_LEN");
   end

   // R5: the mask covers exactly the selected number of bits, newest first
   a_r5_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(win_mask) == win_len_of(win_code_t'(win_sel)));
   a_r5_mask_newest: assert property (@(posedge clk) disable iff (!rst_n)
      win_mask[0]);

endmodule

// File: rtl/arl_rank_history.sv
module arl_rank_history #(
   parameter int HIST_LEN = 20,
   parameter int CNT_W    = $clog2(HIST_LEN + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                issue,
   input  logic [HIST_LEN-1:0] win_mask,
   output logic [CNT_W-1:0]    win_count
);

   logic [HIST_LEN-1:0] hist_q;
   logic [HIST_LEN-1:0] live_bits;

   if (HIST_LEN < 2) begin : g_len_chk
      $error("arl_rank_history: HIST_LEN must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else begin
         hist_q <= {hist_q[HIST_LEN-2:0], issue};
      end
   end

   assign live_bits = hist_q & win_mask;

   always_comb begin
      win_count = '0;
      for (int b = 0; b < HIST_LEN; b++) begin
         win_count = win_count + CNT_W'(live_bits[b]);
      end
   end

   // R1: an issued activate is counted in the following clock
   a_r1_counted_next: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> (win_count != '0));
   // R2: count never exceeds the window length
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      win_count <= CNT_W'($countones(win_mask)));
   // R11: history empty in the first clock after reset
   a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (win_count == '0));

endmodule

// File: rtl/arl_permit_gate.sv
module arl_permit_gate
   import arl_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic               req,
   input  logic               thr_on,
   input  logic [CNT_W-1:0]   win_count,
   input  logic [LIMIT_W-1:0] limit,
   output logic               permit
);

   localparam int CMP_W = (CNT_W > LIMIT_W) ? CNT_W : LIMIT_W;

   logic at_limit;

   assign at_limit = (CMP_W'(win_count) >= CMP_W'(limit));
   assign permit   = req & ~(thr_on & at_limit);

endmodule

// File: rtl/act_rate_limiter.sv
module act_rate_limiter
   import arl_pkg::*;
#(
   parameter int NUM_RANKS     = 4,
   parameter int RANKS_PER_EN  = 2,
   parameter int HIST_LEN      = 20,
   localparam int NUM_EN       = NUM_RANKS / RANKS_PER_EN,
   localparam int CNT_W        = $clog2(HIST_LEN + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RANKS-1:0] act_issued,
   input  logic [NUM_RANKS-1:0] act_req,
   input  logic [NUM_EN-1:0]    thr_en,
   input  logic [1:0]           win_sel,
   input  logic [LIMIT_W-1:0]   act_limit,
   output logic [NUM_RANKS-1:0] act_permit
);

   if (NUM_RANKS < 1 || RANKS_PER_EN < 1 || (NUM_RANKS % RANKS_PER_EN) != 0) begin : g_cfg_chk
      $error("act_rate_limiter: NUM_RANKS must be a multiple of RANKS_PER_EN");
   end

   logic [HIST_LEN-1:0] win_mask;
   logic [CNT_W-1:0]    rank_count [NUM_RANKS];
   logic [NUM_RANKS-1:0] rank_thr;

   arl_window_mask #(.HIST_LEN(HIST_LEN)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_sel  (win_sel),
      .win_mask (win_mask)
   );

   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      if (RANKS_PER_EN == 1) begin : g_own_en
         assign rank_thr[r] = thr_en[r];
      end else begin : g_shared_en
         assign rank_thr[r] = thr_en[r / RANKS_PER_EN];
      end

      arl_rank_history #(.HIST_LEN(HIST_LEN), .CNT_W(CNT_W)) u_hist (
         .clk       (clk),
         .rst_n     (rst_n),
         .issue     (act_issued[r]),
         .win_mask  (win_mask),
         .win_count (rank_count[r])
      );

      arl_permit_gate #(.CNT_W(CNT_W)) u_gate (
         .req       (act_req[r]),
         .thr_on    (rank_thr[r]),
         .win_count (rank_count[r]),
         .limit     (act_limit),
         .permit    (act_permit[r])
      );

      // R3: a rank at or above the limit is blocked while throttled
      a_r3_block: assert property (@(posedge clk) disable iff (!rst_n)
         (thr_en[r / RANKS_PER_EN] && (rank_count[r] >= CNT_W'(act_limit))) |-> !act_permit[r]);
      // R8: no throttle means the request passes unchanged
      a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
         !thr_en[r / RANKS_PER_EN] |-> (act_permit[r] == act_req[r]));
      // R10: no permit without a request
      a_r10_no_req: assert property (@(posedge clk) disable iff (!rst_n)
         !act_req[r] |-> !act_permit[r]);
      // R12: a zero limit blocks every throttled rank
      a_r12_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
         (thr_en[r / RANKS_PER_EN] && act_limit == '0) |-> !act_permit[r]);
      // R1: a fresh activate with a limit of one blocks the next clock
      a_r1_limit_one: assert property (@(posedge clk) disable iff (!rst_n)
         (act_issued[r] && $stable(win_sel)) ##1
         (thr_en[r / RANKS_PER_EN] && act_limit == LIMIT_W'(1)) |-> !act_permit[r]);
   end

endmodule

// File: tb/act_rate_limiter_test.sv
module act_rate_limiter_test;

   localparam int NR = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] act_issued = '0;
   logic [3:0] act_req = '0;
   logic [1:0] thr_en = '0;
   logic [1:0] win_sel = 2'd3;
   logic [2:0] act_limit = 3'd4;
   logic [3:0] act_permit;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int hq [NR][$];
   logic [3:0] exp_p;

   act_rate_limiter uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_issued (act_issued),
      .act_req    (act_req),
      .thr_en     (thr_en),
      .win_sel    (win_sel),
      .act_limit  (act_limit),
      .act_permit (act_permit)
   );

   always #5 clk = ~clk;

   function automatic int wlen(input logic [1:0] s);
      case (s)
         2'd0: return 10;
         2'd1: return 13;
         2'd2: return 15;
         default: return 20;
      endcase
   endfunction

   function automatic int model_count(input int r);
      int n = 0;
      foreach (hq[r][i]) if (cyc - hq[r][i] <= wlen(win_sel)) n++;
      return n;
   endfunction

   task automatic compare(input string tag);
      for (int r = 0; r < NR; r++) begin
         int c = model_count(r);
         bit en = thr_en[r / 2];
         string t = tag;
         exp_p[r] = act_req[r] && !(en && c >= int'(act_limit));
         if (t == "") begin
            if (!act_req[r]) t = "R10";
            else if (!en) t = "R8";
            else if (act_limit == 0) t = "R12";
            else if (c >= int'(act_limit)) t = "R3";
            else t = "R4";
         end
         total++;
         if (act_permit[r] !== exp_p[r]) begin
            bad++;
            $display("FAIL %s rank %0d cycle %0d: permit=%b expected=%b (count=%0d)",
                     t, r, cyc, act_permit[r], exp_p[r], c);
         end
      end
   endtask

   // Called just after a falling edge; compares, then clocks once.
   task automatic step(input logic [3:0] iss, input bit follow, input string tag);
      #1;
      compare(tag);
      if (follow) begin
         for (int r = 0; r < NR; r++) begin
            act_issued[r] = exp_p[r] ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 19) == 0);
         end
      end else begin
         act_issued = iss;
      end
      @(posedge clk);
      for (int r = 0; r < NR; r++) begin
         if (act_issued[r]) hq[r].push_back(cyc);
         while (hq[r].size() > 0 && cyc + 1 - hq[r][0] > 20) void'(hq[r].pop_front());
      end
      cyc++;
      @(negedge clk);
      act_issued = '0;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(4'b0000, 1'b0, tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      act_req = 4'b1111;
      thr_en = 2'b11;
      act_limit = 3'd4;
      win_sel = 2'd3;

      // R11: clean start, every requesting rank permitted
      step(4'b0000, 1'b0, "R11");

      // R1 / R2: four activates on rank 0 in a row, window 20
      step(4'b0001, 1'b0, "R1");
      step(4'b0001, 1'b0, "R1");
      step(4'b0001, 1'b0, "R2");
      step(4'b0001, 1'b0, "R2");
      idle(22, "");

      // R5 / R6: each window length, burst then wait until it ages out
      for (int s = 0; s < 4; s++) begin
         win_sel = 2'(s);
         for (int k = 0; k < 4; k++) step(4'b1111, 1'b0, "R5");
         idle(22, "R6");
      end

      // R6: spread activates so only the newest stay in a short window
      win_sel = 2'd0;
      for (int k = 0; k < 4; k++) begin
         step(4'b0010, 1'b0, "R6");
         idle(4, "R6");
      end
      idle(22, "");

      // R7: only pair 0 throttled
      thr_en = 2'b01;
      win_sel = 2'd3;
      for (int k = 0; k < 6; k++) step(4'b1111, 1'b0, "R7");
      idle(22, "R7");

      // R9: record while disabled, then enable
      thr_en = 2'b00;
      for (int k = 0; k < 5; k++) step(4'b1111, 1'b0, "R9");
      thr_en = 2'b11;
      step(4'b0000, 1'b0, "R9");
      idle(21, "");

      // R12: zero limit
      act_limit = 3'd0;
      idle(3, "R12");

      // R10: requests dropped
      act_limit = 3'd2;
      act_req = 4'b0101;
      for (int k = 0; k < 4; k++) step(4'b1111, 1'b0, "R10");
      idle(22, "");

      // Mixed random traffic; window changes only after quiet periods
      for (int blk = 0; blk < 40; blk++) begin
         win_sel = 2'($urandom_range(0, 3));
         act_limit = 3'($urandom_range(0, 7));
         for (int k = 0; k < 50; k++) begin
            act_req = 4'($urandom_range(0, 15));
            thr_en = 2'($urandom_range(0, 3));
            step(4'b0000, 1'b1, "");
         end
         idle(22, "");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule